// File: doc/BRIEF.md
# Modulo-Depth Sample Ring with Interrupt Flags

This block is a circular store for converted input samples. A producer side offers 16-bit samples on a valid/ready port. Each accepted sample is written at the front index, and the front index then advances. A host side works through plain control pins. It reads any stored entry by index, and it writes back the consumed (rear) index once it has drained entries. It can also program a fill threshold, program an interrupt mask, and clear flags by writing ones.

The depth does not have to be a power of two. The default of 2003 entries wraps both indices by modulus, not by a bit mask, and the pending count is corrected by the depth when the rear index is ahead of the front.

An eight-bit sticky flag register collects the block's own input-side events: threshold reached, overflow, and a bad rear write. It also collects external events, which arrive as one-cycle pulses. The masked flags drive a single registered interrupt line.

The producer port applies no back-pressure. `prod_ready` is low only while reset is asserted and in the first cycle after it, and it is high from then on. A sample offered while the store already holds DEPTH-1 entries is accepted on the handshake but discarded, and it is reported through a flag.

Top module: `sample_ring_irq`

## Requirements
- R1: The front index stays below DEPTH. After an accepted push at index DEPTH-1 it becomes 0.
- R2: A push that is kept writes `prod_data` at the current front index. Reading that index through `rd_idx` returns it on `rd_data` one cycle later.
- R3: `fill_o` equals front minus rear, with DEPTH added when the difference is negative. It is always below DEPTH.
- R4: A host write with `wr_sel`=0 and a value below DEPTH sets the rear index. A value of DEPTH or more leaves the rear index unchanged and sets flag bit 1.
- R5: A push made while `fill_o` is DEPTH-1 is discarded. The front index is unchanged and flag bit 2 is set.
- R6: Flag bit 0 is set in any cycle where the threshold is nonzero and `fill_o` is greater than or equal to it. The threshold is written with `wr_sel`=1, and reset makes it DEPTH/2.
- R7: The flag bits are: 7 command done, 6 counter/timer done, 5 output hardware error, 4 output software error, 3 output empty, 2 input hardware error, 1 input software error, 0 input full. A pulse on bit i of `ext_evt` sets flag bit i.
- R8: Flags are sticky. A host write with `wr_sel`=3 clears every flag bit where `wr_data` has a one. A set event in the same cycle wins over the clear.
- R9: `irq_o` is the OR of (flags AND mask), registered one cycle. The mask is written with `wr_sel`=2. A zero mask keeps `irq_o` low.
- R10: Reset clears the front index, the rear index, all flags, the mask and `irq_o`.
- R11: `prod_ready` is low during reset and high from the second cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_valid | input | 1 | Producer sample valid |
| prod_ready | output | 1 | Producer ready (no back-pressure) |
| prod_data | input | 16 | Producer sample |
| rd_idx | input | 11 | Host read index |
| rd_data | output | 16 | Entry at rd_idx, one cycle later |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | 0 rear, 1 threshold, 2 mask, 3 flag clear |
| wr_data | input | 16 | Host write value |
| ext_evt | input | 8 | External event pulses, one per flag bit |
| front_o | output | 11 | Front index |
| rear_o | output | 11 | Rear index |
| fill_o | output | 11 | Pending entry count |
| flags_o | output | 8 | Sticky flag register |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the host never writes a rear index that passes the front index. From this they conclude that the count stays in range and that the front index holds still on a discarded push. The stimulus moves the rear index only to values the front index has already reached, or to out-of-range values whose write must be ignored.

The assertions also assume that external events arrive as single-cycle pulses. The stimulus keeps `ext_evt` at zero except for one-cycle pulses, and it sometimes places a pulse on the same cycle as a clear of the same bit.

// File: rtl/smpring_pkg.sv
package smpring_pkg;
  typedef enum logic [1:0] {
    SEL_REAR    = 2'd0,
    SEL_THRESH  = 2'd1,
    SEL_MASK    = 2'd2,
    SEL_FLAGCLR = 2'd3
  } host_sel_e;

  localparam int FLG_W        = 8;
  localparam int FLG_IN_FULL  = 0;
  localparam int FLG_IN_SWERR = 1;
  localparam int FLG_IN_HWERR = 2;
endpackage

// File: rtl/ring_ptrs.sv
module ring_ptrs #(
  parameter int DEPTH = 2003,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [PW-1:0] rear_i,
  output logic [PW-1:0] front_o,
  output logic [PW-1:0] count_o,
  output logic          keep_o,
  output logic          drop_o
);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [PW:0]   DEPW  = (PW + 1)'(DEPTH);

  logic [PW-1:0] front_q;
  logic [PW:0]   diff;

  always_comb begin
    if (front_q >= rear_i) diff = {1'b0, front_q} - {1'b0, rear_i};
    else                   diff = {1'b0, front_q} + DEPW - {1'b0, rear_i};
  end

  assign count_o = diff[PW-1:0];
  assign drop_o  = push_req && (count_o == LAST);
  assign keep_o  = push_req && !drop_o;
  assign front_o = front_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      front_q <= '0;
    else if (keep_o) front_q <= (front_q == LAST) ? '0 : front_q + 1'b1;
  end

  // R1
  front_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    front_q <= LAST);
  // R1
  front_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_o && front_q == LAST) |=> (front_q == '0));
  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= LAST);
  // R5
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> $stable(front_q));
endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int DEPTH = 2003,
  parameter int DW    = 16,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr <= LAST) mem[waddr] <= wdata;
    if (raddr <= LAST) rdata <= mem[raddr];
    else               rdata <= '0;
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_vec,
  input  logic [FW-1:0] clr_vec,
  input  logic          mask_we,
  input  logic [FW-1:0] mask_d,
  output logic [FW-1:0] flags_o,
  output logic          irq_o
);
  logic [FW-1:0] flags_q, mask_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_d;
      irq_q <= |(flags_q & mask_q);
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags_q) & ~$past(clr_vec)) & ~flags_q) == '0));
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
  // R9
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_q);
endmodule

// File: rtl/sample_ring_irq.sv
module sample_ring_irq #(
  parameter int DEPTH = 2003,
  parameter int DW    = 16,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       prod_valid,
  output logic                       prod_ready,
  input  logic [DW-1:0]              prod_data,
  input  logic [PW-1:0]              rd_idx,
  output logic [DW-1:0]              rd_data,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_sel,
  input  logic [DW-1:0]              wr_data,
  input  logic [smpring_pkg::FLG_W-1:0] ext_evt,
  output logic [PW-1:0]              front_o,
  output logic [PW-1:0]              rear_o,
  output logic [PW-1:0]              fill_o,
  output logic [smpring_pkg::FLG_W-1:0] flags_o,
  output logic                       irq_o
);
  import smpring_pkg::*;

  localparam logic [DW-1:0] DEPTH_W = DW'(DEPTH);
  localparam logic [PW-1:0] HALF    = PW'(DEPTH / 2);

  host_sel_e     sel;
  logic [PW-1:0] rear_q, thr_q, front, count;
  logic          ready_q, keep, drop, push_req;
  logic          rear_hit, rear_ok, rear_bad, full_evt;
  logic [FLG_W-1:0] set_vec, clr_vec;

  assign sel      = host_sel_e'(wr_sel);
  assign push_req = prod_valid && ready_q;
  assign rear_hit = wr_en && (sel == SEL_REAR);
  assign rear_ok  = rear_hit && (wr_data < DEPTH_W);
  assign rear_bad = rear_hit && !(wr_data < DEPTH_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rear_q  <= '0;
      thr_q   <= HALF;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (rear_ok) rear_q <= wr_data[PW-1:0];
      if (wr_en && sel == SEL_THRESH) thr_q <= wr_data[PW-1:0];
    end
  end

  ring_ptrs #(.DEPTH(DEPTH), .PW(PW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .rear_i(rear_q),
    .front_o(front), .count_o(count), .keep_o(keep), .drop_o(drop)
  );

  ring_store #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_store (
    .clk(clk), .we(keep), .waddr(front), .wdata(prod_data),
    .raddr(rd_idx), .rdata(rd_data)
  );

  assign full_evt = (thr_q != '0) && (count >= thr_q);

  always_comb begin
    set_vec               = ext_evt;
    set_vec[FLG_IN_FULL]  = ext_evt[FLG_IN_FULL]  | full_evt;
    set_vec[FLG_IN_SWERR] = ext_evt[FLG_IN_SWERR] | rear_bad;
    set_vec[FLG_IN_HWERR] = ext_evt[FLG_IN_HWERR] | drop;
    clr_vec = (wr_en && sel == SEL_FLAGCLR) ? wr_data[FLG_W-1:0] : '0;
  end

  irq_flags #(.FW(FLG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask_we(wr_en && sel == SEL_MASK), .mask_d(wr_data[FLG_W-1:0]),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  assign prod_ready = ready_q;
  assign front_o    = front;
  assign rear_o     = rear_q;
  assign fill_o     = count;

  // R4
  rear_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rear_bad |=> $stable(rear_q));
  // R5
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> flags_o[FLG_IN_HWERR]);
  // R11
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prod_ready);
endmodule

// File: tb/sim_sample_ring_irq.sv
module sim_sample_ring_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prod_valid = 1'b0, wr_en = 1'b0;
  logic [15:0] prod_data = '0, wr_data = '0;
  logic [10:0] rd_idx = '0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  ext_evt = '0;
  logic prod_ready, irq_o;
  logic [15:0] rd_data;
  logic [10:0] front_o, rear_o, fill_o;
  logic [7:0]  flags_o;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sample_ring_irq u0 (
    .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .prod_ready(prod_ready),
    .prod_data(prod_data), .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ext_evt(ext_evt), .front_o(front_o),
    .rear_o(rear_o), .fill_o(fill_o), .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_n(int n, int base);
    for (int i = 0; i < n; i++) begin
      prod_data = 16'(base + i); prod_valid = 1'b1;
      @(negedge clk);
    end
    prod_valid = 1'b0;
  endtask

  task automatic hwrite(int sel, int val);
    wr_sel = 2'(sel); wr_data = 16'(val); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 ready low in reset", prod_ready, 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 front", front_o, 0);
    chk("R10 rear", rear_o, 0);
    chk("R10 flags", flags_o, 0);
    chk("R10 irq", irq_o, 0);
    chk("R11 ready", prod_ready, 1);
  endtask

  task automatic t_push_read;
    push_n(5, 16'hA000);
    chk("R3 fill 5", fill_o, 5);
    for (int i = 0; i < 5; i++) begin
      rd_idx = 11'(i); @(negedge clk);
      chk("R2 read back", rd_data, 16'hA000 + i);
    end
  endtask

  task automatic t_threshold_default;
    push_n(995, 5);
    @(negedge clk);
    chk("R6 below default thr", flags_o[0], 0);
    push_n(1, 1000);
    chk("R6 flag lag", flags_o[0], 0);
    @(negedge clk);
    chk("R6 at default thr", flags_o[0], 1);
  endtask

  task automatic t_overflow;
    push_n(1001, 1001);
    chk("R5 fill full", fill_o, 2002);
    chk("R5 front", front_o, 2002);
    chk("R5 no hw err yet", flags_o[2], 0);
    push_n(1, 16'hDEAD);
    chk("R5 front held", front_o, 2002);
    chk("R5 hw err flag", flags_o[2], 1);
    rd_idx = 11'd1500; @(negedge clk);
    chk("R2 deep read", rd_data, 1500);
  endtask

  task automatic t_rear_wrap;
    hwrite(0, 2002);
    chk("R4 rear set", rear_o, 2002);
    chk("R3 fill zero", fill_o, 0);
    hwrite(0, 2003);
    chk("R4 bad rear ignored", rear_o, 2002);
    chk("R4 sw err flag", flags_o[1], 1);
    push_n(1, 16'h5A5A);
    chk("R1 front wraps", front_o, 0);
    chk("R3 negative diff", fill_o, 1);
    rd_idx = 11'd2002; @(negedge clk);
    chk("R2 last slot", rd_data, 16'h5A5A);
  endtask

  task automatic t_flags;
    hwrite(3, 8'hFF);
    chk("R8 w1c all", flags_o, 0);
    ext_evt = 8'h78; @(negedge clk); ext_evt = 8'h00;
    chk("R7 ext events", flags_o, 8'h78);
    @(negedge clk);
    chk("R9 zero mask", irq_o, 0);
    hwrite(2, 8'h08);
    chk("R9 irq lag", irq_o, 0);
    @(negedge clk);
    chk("R9 irq up", irq_o, 1);
    ext_evt = 8'h08; hwrite(3, 8'h08); ext_evt = 8'h00;
    chk("R8 set wins", flags_o[3], 1);
    hwrite(3, 8'h78);
    chk("R8 cleared", flags_o, 0);
    @(negedge clk);
    chk("R9 irq down", irq_o, 0);
    ext_evt = 8'h80; @(negedge clk); ext_evt = 8'h00;
    chk("R7 cmd done bit", flags_o, 8'h80);
    hwrite(3, 8'h80);
  endtask

  task automatic t_thr_prog;
    hwrite(1, 2);
    hwrite(2, 8'h01);
    push_n(1, 7);
    chk("R6 programmed fill", fill_o, 2);
    @(negedge clk);
    chk("R6 programmed thr", flags_o[0], 1);
    @(negedge clk);
    chk("R9 irq from full", irq_o, 1);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_push_read;
    t_threshold_default;
    t_overflow;
    t_rear_wrap;
    t_flags;
    t_thr_prog;
    finish_up;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up;
  end
endmodule